// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns one operand-addressing request into a segment-relative offset, a segment choice and a 20-bit physical address. A request carries an addressing mode, the codes of the base and index registers it names, a displacement, a displacement-width flag and an optional segment override. The current pointer register values (BX, BP, SI, DI) and segment register values (ES, CS, SS, DS) are plain inputs, read in the same cycle as the request.

The offset is the sum of the registers the mode names and the displacement, taken modulo 2^16. The segment is the data segment by default and the stack segment whenever BP is the base; an override replaces either default. The physical address is the segment value shifted left by four bits plus the offset, taken modulo 2^20. A request that names a register the mode does not allow raises an error flag and returns all-zero address fields.

Requests enter on a valid/ready port and results leave on a valid/ready port. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. While a result waits, it stays unchanged and the input stalls. With the default `REG_OUT = 1`, one result register sits between the two ports. With `REG_OUT = 0`, the path is purely combinational and the ready signal passes straight through.

Top module: `seg_addr_gen`

## Requirements
- R1: `out_phys` equals the selected segment value times 16 plus `out_offset`, modulo 2^20. For example, DS = 2000h with offset 0150h gives 20150h, and DS = FFFFh with offset 0010h gives 00000h.
- R2: Offset sums wrap modulo 2^16. For example, BX = FFFEh plus displacement 4 gives offset 0002h.
- R3: In every mode except direct, `in_disp_wide = 0` uses `in_disp[7:0]` sign-extended to 16 bits and ignores the upper byte, while `in_disp_wide = 1` uses all 16 bits. Direct mode always uses all 16 bits, whatever the flag.
- R4: Mode codes and offsets are as follows. Register codes are BX = 3, BP = 5, SI = 6 and DI = 7; `in_base` and `in_index` carry these codes, and any other code on them is an unlisted register.

  | Code | Mode | Offset | Registers allowed |
  |---|---|---|---|
  | 0 | direct | `in_disp` | none |
  | 1 | register-indirect | value of the register in `in_base` | BX, BP, SI or DI |
  | 2 | based | base + displacement | base BX or BP |
  | 3 | indexed | index + displacement | index SI or DI |
  | 4 | based-indexed | base + index | base BX or BP, index SI or DI |
  | 5 | based-indexed with displacement | base + index + displacement | base BX or BP, index SI or DI |

- R5: Without an override, the segment is SS (code 2) when BP is the base in modes 1, 2, 4 or 5. Otherwise it is DS (code 3). `out_seg` codes are ES = 0, CS = 1, SS = 2 and DS = 3.
- R6: When `in_ovr_en = 1`, the segment is the one named by `in_ovr_seg` (using the codes of R5), in every legal mode.
- R7: The request is illegal when the mode code is 6 or 7, or when it names a register that R4 does not allow for that mode. An illegal request gives `out_err = 1` with `out_offset`, `out_seg` and `out_phys` all zero, even when an override is requested.
- R8: With `REG_OUT = 1`, an accepted request shows up on the output, with `out_valid` high, in the cycle after acceptance. `in_ready` is high exactly when the output register is empty or is being consumed. A result held while `out_ready` is low stays unchanged, and results come out in request order.
- R9: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_mode | input | 3 | Addressing mode code |
| in_base | input | 3 | Base or pointer register code |
| in_index | input | 3 | Index register code |
| in_disp | input | 16 | Displacement or direct offset |
| in_disp_wide | input | 1 | 1 selects a 16-bit displacement, 0 an 8-bit one |
| in_ovr_en | input | 1 | Segment override requested |
| in_ovr_seg | input | 2 | Override segment code |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result can be consumed |
| out_err | output | 1 | Illegal request |
| out_seg | output | 2 | Selected segment code |
| out_offset | output | 16 | Effective offset |
| out_phys | output | 20 | Physical address |

## Verification
Two functions can fall in the same cycle: taking a new request into the result register and handing the waiting result to the consumer. The bench provokes this by streaming requests while `out_ready` follows a pattern that is mostly high with some low cycles. It also holds `out_ready` low for several cycles, so the input must stall and the held result must stay in place. A scoreboard compares each consumed result against a queue of expected values computed from the rules above. A lost, duplicated or overwritten result therefore shows up as a wrong value or a wrong count.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int OFS_W     = 16;
  localparam int SEG_W     = 16;
  localparam int SEG_SHIFT = 4;
  localparam int DISP_N_W  = 8;
  localparam int MODE_W    = 3;
  localparam int RCODE_W   = 3;
  localparam int SEGID_W   = 2;

  localparam logic [MODE_W-1:0] AM_DIRECT   = 3'd0;
  localparam logic [MODE_W-1:0] AM_INDIRECT = 3'd1;
  localparam logic [MODE_W-1:0] AM_BASED    = 3'd2;
  localparam logic [MODE_W-1:0] AM_INDEXED  = 3'd3;
  localparam logic [MODE_W-1:0] AM_BIX      = 3'd4;
  localparam logic [MODE_W-1:0] AM_BIX_DISP = 3'd5;

  localparam logic [RCODE_W-1:0] RC_BX = 3'd3;
  localparam logic [RCODE_W-1:0] RC_BP = 3'd5;
  localparam logic [RCODE_W-1:0] RC_SI = 3'd6;
  localparam logic [RCODE_W-1:0] RC_DI = 3'd7;

  localparam logic [SEGID_W-1:0] SG_ES = 2'd0;
  localparam logic [SEGID_W-1:0] SG_CS = 2'd1;
  localparam logic [SEGID_W-1:0] SG_SS = 2'd2;
  localparam logic [SEGID_W-1:0] SG_DS = 2'd3;
endpackage

// File: rtl/eag_offset.sv
module eag_offset
  import eag_pkg::*;
#(
  parameter int OW = OFS_W,
  parameter int NW = DISP_N_W
) (
  input  logic [MODE_W-1:0]  mode,
  input  logic [RCODE_W-1:0] base_code,
  input  logic [RCODE_W-1:0] index_code,
  input  logic [OW-1:0]      disp,
  input  logic               disp_wide,
  input  logic [OW-1:0]      bx,
  input  logic [OW-1:0]      bp,
  input  logic [OW-1:0]      si,
  input  logic [OW-1:0]      di,
  output logic [OW-1:0]      offset,
  output logic               uses_bp,
  output logic               illegal
);
  logic [OW-1:0] disp_ext, base_val, idx_val, ptr_val;
  logic          base_ok, idx_ok, ptr_ok, base_is_bp;

  always_comb begin
    disp_ext = disp_wide ? disp : {{(OW-NW){disp[NW-1]}}, disp[NW-1:0]};

    base_ok = 1'b1; base_val = '0; base_is_bp = 1'b0;
    case (base_code)
      RC_BX:   base_val = bx;
      RC_BP:   begin base_val = bp; base_is_bp = 1'b1; end
      default: base_ok = 1'b0;
    endcase

    idx_ok = 1'b1; idx_val = '0;
    case (index_code)
      RC_SI:   idx_val = si;
      RC_DI:   idx_val = di;
      default: idx_ok = 1'b0;
    endcase

    ptr_ok = 1'b1; ptr_val = '0;
    case (base_code)
      RC_BX:   ptr_val = bx;
      RC_BP:   ptr_val = bp;
      RC_SI:   ptr_val = si;
      RC_DI:   ptr_val = di;
      default: ptr_ok = 1'b0;
    endcase
  end

  always_comb begin
    offset  = '0;
    uses_bp = 1'b0;
    illegal = 1'b0;
    case (mode)
      AM_DIRECT: offset = disp;
      AM_INDIRECT: begin
        offset  = ptr_val;
        uses_bp = (base_code == RC_BP);
        illegal = !ptr_ok;
      end
      AM_BASED: begin
        offset  = base_val + disp_ext;
        uses_bp = base_is_bp;
        illegal = !base_ok;
      end
      AM_INDEXED: begin
        offset  = idx_val + disp_ext;
        illegal = !idx_ok;
      end
      AM_BIX, AM_BIX_DISP: begin
        offset  = base_val + idx_val + ((mode == AM_BIX_DISP) ? disp_ext : '0);
        uses_bp = base_is_bp;
        illegal = !(base_ok && idx_ok);
      end
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/eag_segsel.sv
module eag_segsel
  import eag_pkg::*;
#(
  parameter int OW = OFS_W,
  parameter int SW = SEG_W,
  parameter int SH = SEG_SHIFT,
  localparam int PW = SW + SH
) (
  input  logic [OW-1:0]      offset,
  input  logic               uses_bp,
  input  logic               illegal,
  input  logic               ovr_en,
  input  logic [SEGID_W-1:0] ovr_seg,
  input  logic [SW-1:0]      es,
  input  logic [SW-1:0]      cs,
  input  logic [SW-1:0]      ss,
  input  logic [SW-1:0]      ds,
  output logic [SEGID_W-1:0] seg_id,
  output logic [OW-1:0]      ofs_out,
  output logic [PW-1:0]      phys
);
  logic [SEGID_W-1:0] pick;
  logic [SW-1:0]      seg_val;
  logic [PW-1:0]      sum;

  always_comb begin
    pick = ovr_en ? ovr_seg : (uses_bp ? SG_SS : SG_DS);
    case (pick)
      SG_ES:   seg_val = es;
      SG_CS:   seg_val = cs;
      SG_SS:   seg_val = ss;
      default: seg_val = ds;
    endcase
    sum     = {seg_val, {SH{1'b0}}} + PW'(offset);
    seg_id  = illegal ? '0 : pick;
    ofs_out = illegal ? '0 : offset;
    phys    = illegal ? '0 : sum;
  end
endmodule

// File: rtl/eag_outstage.sv
module eag_outstage #(
  parameter int DW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic          v_q;
      logic [DW-1:0] d_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else if (in_ready) begin
          v_q <= in_valid;
          if (in_valid) d_q <= in_data;
        end
      end

      assign in_ready  = !v_q || out_ready;
      assign out_valid = v_q;
      assign out_data  = d_q;

      a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
      a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import eag_pkg::*;
#(
  parameter int OW      = OFS_W,
  parameter int SW      = SEG_W,
  parameter int SH      = SEG_SHIFT,
  parameter int NW      = DISP_N_W,
  parameter bit REG_OUT = 1'b1,
  localparam int PW = SW + SH,
  localparam int DW = 1 + SEGID_W + OW + PW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [MODE_W-1:0]  in_mode,
  input  logic [RCODE_W-1:0] in_base,
  input  logic [RCODE_W-1:0] in_index,
  input  logic [OW-1:0]      in_disp,
  input  logic               in_disp_wide,
  input  logic               in_ovr_en,
  input  logic [SEGID_W-1:0] in_ovr_seg,
  input  logic [OW-1:0]      reg_bx,
  input  logic [OW-1:0]      reg_bp,
  input  logic [OW-1:0]      reg_si,
  input  logic [OW-1:0]      reg_di,
  input  logic [SW-1:0]      seg_es,
  input  logic [SW-1:0]      seg_cs,
  input  logic [SW-1:0]      seg_ss,
  input  logic [SW-1:0]      seg_ds,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_err,
  output logic [SEGID_W-1:0] out_seg,
  output logic [OW-1:0]      out_offset,
  output logic [PW-1:0]      out_phys
);
  logic [OW-1:0]      raw_ofs, c_ofs;
  logic               c_bp, c_err;
  logic [SEGID_W-1:0] c_seg;
  logic [PW-1:0]      c_phys;
  logic [DW-1:0]      st_in, st_out;

  eag_offset #(.OW(OW), .NW(NW)) u_ofs (
    .mode(in_mode), .base_code(in_base), .index_code(in_index),
    .disp(in_disp), .disp_wide(in_disp_wide),
    .bx(reg_bx), .bp(reg_bp), .si(reg_si), .di(reg_di),
    .offset(raw_ofs), .uses_bp(c_bp), .illegal(c_err)
  );

  eag_segsel #(.OW(OW), .SW(SW), .SH(SH)) u_seg (
    .offset(raw_ofs), .uses_bp(c_bp), .illegal(c_err),
    .ovr_en(in_ovr_en), .ovr_seg(in_ovr_seg),
    .es(seg_es), .cs(seg_cs), .ss(seg_ss), .ds(seg_ds),
    .seg_id(c_seg), .ofs_out(c_ofs), .phys(c_phys)
  );

  assign st_in = {c_err, c_seg, c_ofs, c_phys};

  eag_outstage #(.DW(DW), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(st_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(st_out)
  );

  assign {out_err, out_seg, out_offset, out_phys} = st_out;

  a_r1_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !c_err) |-> (c_phys[SH-1:0] == c_ofs[SH-1:0]));
  a_r5_direct_ds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ovr_en && in_mode == AM_DIRECT) |-> (c_seg == SG_DS && !c_err));
  a_r6_override: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ovr_en && !c_err) |-> (c_seg == in_ovr_seg));
  a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_phys == '0 && out_offset == '0 && out_seg == '0));
  a_r9_reset: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && in_ready));
endmodule

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1, out_err;
  logic [2:0] in_mode = '0, in_base = '0, in_index = '0;
  logic [15:0] in_disp = '0;
  logic in_disp_wide = 1'b0, in_ovr_en = 1'b0;
  logic [1:0] in_ovr_seg = '0, out_seg;
  logic [15:0] bx = '0, bp = '0, si = '0, di = '0;
  logic [15:0] es = '0, cs = '0, ss = '0, ds = '0;
  logic [15:0] out_offset;
  logic [19:0] out_phys;

  int checks = 0, fails = 0, cyc = 0;
  bit hold = 1'b0, jitter = 1'b0;
  logic [38:0] expq[$];
  string tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_base(in_base), .in_index(in_index),
    .in_disp(in_disp), .in_disp_wide(in_disp_wide),
    .in_ovr_en(in_ovr_en), .in_ovr_seg(in_ovr_seg),
    .reg_bx(bx), .reg_bp(bp), .reg_si(si), .reg_di(di),
    .seg_es(es), .seg_cs(cs), .seg_ss(ss), .seg_ds(ds),
    .out_valid(out_valid), .out_ready(out_ready), .out_err(out_err),
    .out_seg(out_seg), .out_offset(out_offset), .out_phys(out_phys)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [38:0] model(input logic [2:0] m, input logic [2:0] b, input logic [2:0] ix,
                                        input logic [15:0] d, input logic w, input logic oe, input logic [1:0] os);
    logic [15:0] ext, bv, iv, ofs, sv;
    logic bok, iok, bad, usebp;
    logic [1:0] sg;
    logic [19:0] ph;
    ext = w ? d : {{8{d[7]}}, d[7:0]};
    bok = (b == 3'd3) || (b == 3'd5);
    bv  = (b == 3'd3) ? bx : bp;
    iok = (ix == 3'd6) || (ix == 3'd7);
    iv  = (ix == 3'd6) ? si : di;
    bad = 1'b0; usebp = 1'b0; ofs = '0;
    case (m)
      3'd0: ofs = d;
      3'd1: begin
        case (b)
          3'd3: ofs = bx;
          3'd5: begin ofs = bp; usebp = 1'b1; end
          3'd6: ofs = si;
          3'd7: ofs = di;
          default: bad = 1'b1;
        endcase
      end
      3'd2: begin ofs = bv + ext; bad = !bok; usebp = (b == 3'd5); end
      3'd3: begin ofs = iv + ext; bad = !iok; end
      3'd4: begin ofs = bv + iv; bad = !(bok && iok); usebp = (b == 3'd5); end
      3'd5: begin ofs = bv + iv + ext; bad = !(bok && iok); usebp = (b == 3'd5); end
      default: bad = 1'b1;
    endcase
    sg = oe ? os : (usebp ? 2'd2 : 2'd3);
    case (sg)
      2'd0: sv = es;
      2'd1: sv = cs;
      2'd2: sv = ss;
      default: sv = ds;
    endcase
    ph = {sv, 4'h0} + {4'h0, ofs};
    if (bad) return {1'b1, 2'd0, 16'd0, 20'd0};
    return {1'b0, sg, ofs, ph};
  endfunction

  task automatic send(input string tag, input logic [2:0] m, input logic [2:0] b, input logic [2:0] ix,
                      input logic [15:0] d, input logic w, input logic oe, input logic [1:0] os);
    @(negedge clk);
    in_mode = m; in_base = b; in_index = ix; in_disp = d;
    in_disp_wide = w; in_ovr_en = oe; in_ovr_seg = os; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    expq.push_back(model(m, b, ix, d, w, oe, os));
    tagq.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    cyc++;
    out_ready = hold ? 1'b0 : (jitter ? ((cyc % 4) != 1) : 1'b1);
  end

  initial begin : monitor
    logic [38:0] e, a;
    string t;
    forever begin
      @(negedge clk); #1;
      if (rst_n && out_valid && out_ready) begin
        a = {out_err, out_seg, out_offset, out_phys};
        if (expq.size() == 0) begin
          check(1'b0, "R8 unexpected result", 64'(a), 64'd0);
        end else begin
          e = expq.pop_front();
          t = tagq.pop_front();
          check(a == e, t, 64'(a), 64'(e));
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog expired", 64'(cyc), 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && in_ready, "R9 reset state", {62'd0, out_valid, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!out_valid && in_ready, "R9 after reset", {62'd0, out_valid, in_ready}, 64'd1);

    bx = 16'h0150; bp = 16'h0200; si = 16'h0030; di = 16'h0044;
    es = 16'h1000; cs = 16'h3000; ss = 16'h4000; ds = 16'h2000;
    send("R1 direct 2000:0150", 3'd0, 3'd0, 3'd0, 16'h0150, 1'b1, 1'b0, 2'd0);
    send("R3 direct ignores narrow flag", 3'd0, 3'd0, 3'd0, 16'h0080, 1'b0, 1'b0, 2'd0);
    send("R4 indirect BX", 3'd1, 3'd3, 3'd0, 16'h0000, 1'b0, 1'b0, 2'd0);
    send("R4 indirect SI", 3'd1, 3'd6, 3'd0, 16'h1234, 1'b1, 1'b0, 2'd0);
    send("R4 indirect DI", 3'd1, 3'd7, 3'd0, 16'h0000, 1'b0, 1'b0, 2'd0);
    send("R5 indirect BP uses SS", 3'd1, 3'd5, 3'd0, 16'h0000, 1'b0, 1'b0, 2'd0);
    send("R5 based BP+6 uses SS", 3'd2, 3'd5, 3'd0, 16'h0006, 1'b0, 1'b0, 2'd0);
    send("R4 indexed DI+10", 3'd3, 3'd0, 3'd7, 16'h000A, 1'b0, 1'b0, 2'd0);
    send("R4 based-indexed BX+SI", 3'd4, 3'd3, 3'd6, 16'h0000, 1'b0, 1'b0, 2'd0);
    send("R5 based-indexed BP+DI uses SS", 3'd4, 3'd5, 3'd7, 16'h0000, 1'b0, 1'b0, 2'd0);
    send("R4 BP+DI+disp", 3'd5, 3'd5, 3'd7, 16'h0010, 1'b0, 1'b0, 2'd0);
    send("R6 override ES on BP", 3'd1, 3'd5, 3'd0, 16'h0000, 1'b0, 1'b1, 2'd0);
    send("R6 override CS on direct", 3'd0, 3'd0, 3'd0, 16'h0022, 1'b1, 1'b1, 2'd1);
    send("R6 override DS on BP+SI", 3'd4, 3'd5, 3'd6, 16'h0000, 1'b0, 1'b1, 2'd3);

    ds = 16'hFFFF; bx = 16'hFFFE;
    send("R1 physical wrap", 3'd0, 3'd0, 3'd0, 16'h0010, 1'b1, 1'b0, 2'd0);
    send("R2 offset wrap BX+4", 3'd2, 3'd3, 3'd0, 16'h0004, 1'b0, 1'b0, 2'd0);
    bx = 16'h1000; ds = 16'h2000;
    send("R3 narrow negative, upper byte ignored", 3'd2, 3'd3, 3'd0, 16'hAB80, 1'b0, 1'b0, 2'd0);
    send("R3 narrow FC sign-extended", 3'd2, 3'd3, 3'd0, 16'h00FC, 1'b0, 1'b0, 2'd0);
    send("R3 wide 00FC", 3'd2, 3'd3, 3'd0, 16'h00FC, 1'b1, 1'b0, 2'd0);

    send("R7 mode 6", 3'd6, 3'd3, 3'd6, 16'h0001, 1'b0, 1'b0, 2'd0);
    send("R7 mode 7 with override", 3'd7, 3'd3, 3'd6, 16'h0001, 1'b0, 1'b1, 2'd1);
    send("R7 indirect AX", 3'd1, 3'd0, 3'd0, 16'h0000, 1'b0, 1'b0, 2'd0);
    send("R7 based with SI", 3'd2, 3'd6, 3'd0, 16'h0004, 1'b0, 1'b0, 2'd0);
    send("R7 indexed with BX", 3'd3, 3'd0, 3'd3, 16'h0004, 1'b0, 1'b0, 2'd0);
    send("R7 BX+BX", 3'd5, 3'd3, 3'd3, 16'h0004, 1'b0, 1'b1, 2'd2);

    // R8: stall the consumer and check latency, hold and input stall
    repeat (3) @(negedge clk);
    hold = 1'b1;
    send("R8 held result", 3'd3, 3'd0, 3'd6, 16'h0100, 1'b1, 1'b0, 2'd0);
    #1;
    check(out_valid, "R8 valid one cycle after accept", {63'd0, out_valid}, 64'd1);
    repeat (3) @(negedge clk);
    #1;
    check(!in_ready && out_valid, "R8 stall while full", {62'd0, in_ready, out_valid}, 64'd1);
    hold = 1'b0;

    // R8: streaming under an irregular ready pattern
    jitter = 1'b1;
    for (int k = 0; k < 24; k++) begin
      bx = 16'(k * 16'h0111); si = 16'(16'hF000 + k); bp = 16'(k * 7);
      send("R8 stream", 3'(k % 6), (k % 2 == 0) ? 3'd3 : 3'd5, (k % 3 == 0) ? 3'd6 : 3'd7,
           16'(k * 16'h0093), k[0], (k % 5 == 0), 2'(k % 4));
    end
    jitter = 1'b0;

    repeat (10) @(negedge clk);
    check(expq.size() == 0, "R8 all results delivered", 64'(expq.size()), 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule